// File: doc/BRIEF.md
# VRAM Block Copy Engine

This block copies data from anywhere in the CPU address space into video memory without the CPU having to move each byte. Software loads a 16-bit source pointer and a 16-bit destination pointer through four byte registers. It then writes a fifth register, the length/mode byte, to request a copy. Copies always move whole 16-byte blocks. The destination always falls inside the 8 KiB video window at 0x8000.

Two kinds of request exist:

- **Bulk copy.** The CPU is held until every byte has been moved.
- **Paced copy.** One 16-byte block moves on each rising edge of the horizontal-blank input. The length/mode register counts the blocks down as they go, so software can see how far a paced copy has progressed. Software can also cancel a paced copy early.

While any bytes are in flight, the stall output holds the CPU. The engine moves one byte every two clock cycles, reading the source through a read port and writing video memory through a write port.

Top module: `vram_copy_engine`

## Requirements
- R1: After reset, register indices 0–3 read 0x00, index 4 reads 0xFF, indices 5–7 read 0xFF, the stall output is low and no video write occurs.
- R2: The source of a copy is {index0, index1} with bits [3:0] cleared, so the first byte is read from a 16-byte aligned address.
- R3: The destination of a copy is 0x8000 | ({index2, index3} & 0x1FF0). While the copy advances, the destination increments within 0x8000–0x9FFF and wraps from 0x9FFF to 0x8000.
- R4: A write to index 4 whose aligned source lies in 0x8000–0x9FFF is dropped. No byte moves, the stall stays low, and index 4 keeps its previous value.
- R5: Writing index 4 with bit 7 = 0 while no paced copy is armed starts a bulk copy of (bits[6:0] + 1) × 16 bytes. The stall rises in the cycle after the write and stays high for exactly 2 cycles per byte. Exactly one byte is written every second cycle, with the source and destination each advancing by one.
- R6: When a bulk copy ends, index 4 reads 0xFF. Indices 0–3 then hold the final source and destination, meaning the addresses one past the last byte copied.
- R7: Writing index 4 with bit 7 = 1 while the video mode input is not 0 arms a paced copy of bits[6:0] + 1 blocks, without moving any byte yet. Index 4 then reads {0, bits[6:0]}. Each rising edge of the horizontal-blank input moves one 16-byte block and decrements index 4. After the last block, index 4 reads 0xFF and further edges move nothing.
- R8: Writing index 4 with bit 7 = 1 while the video mode input is 0 arms a paced copy and moves its first block at once.
- R9: Writing index 4 with bit 7 = 0 while a paced copy is armed and the video mode input is not 0 cancels the paced copy. No byte moves, and index 4 reads {1, remaining count}.
- R10: Writing index 4 with bit 7 = 0 while a paced copy is armed and the video mode input is 0 drops the paced copy and starts a bulk copy of the full new length.
- R11: After every paced block, indices 0–3 hold the source and destination that follow that block, and the next block continues from there.
- R12: The stall output is high in exactly those cycles that belong to a run of byte moves, and every video write falls inside such a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| hblank | input | 1 | Horizontal-blank level; rising edge paces blocks |
| videoMode | input | 2 | Current video mode; 0 means horizontal blank |
| cpuStall | output | 1 | High while bytes are being moved |
| memRdEn | output | 1 | Source read strobe |
| memRdAddr | output | 16 | Source address |
| memRdData | input | 8 | Source data, valid in the same cycle as the address |
| vramWrEn | output | 1 | Video memory write strobe |
| vramWrAddr | output | 16 | Video memory write address |
| vramWrData | output | 8 | Video memory write data |

## Verification
The checks assume that the CPU side never writes a register while the stall output is high, because a stalled CPU cannot issue accesses. The bench only drives register writes after it has waited for the stall to fall. The read port is assumed to answer combinationally in the same cycle as the address. The bench memory model is a pure function of the address, so every copied byte can be predicted from its source address. Horizontal-blank pulses are issued only while the engine is idle, and the video mode is changed only between register writes.

// File: rtl/vram_copy_pkg.sv
package vram_copy_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int LEN_BITS = DATA_W - 1;
  localparam int PTR_REGS = 4;
  localparam logic [2:0] LEN_IDX = 3'd4;

  typedef struct packed {
    logic load;
    logic step;
    logic writeBack;
    logic byteWrite;
  } dpStrobe_t;
endpackage

// File: rtl/vram_copy_dp.sv
module vram_copy_dp
  import vram_copy_pkg::*;
#(
  parameter int BLOCK_BYTES = 16,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
  parameter int VRAM_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] dpRdData,
  output logic              srcInvalid,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              vramWrEn,
  output logic [ADDR_W-1:0] vramWrAddr,
  output logic [DATA_W-1:0] vramWrData
);
  localparam int ALIGN_BITS = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BLOCK_BYTES - 1);
  localparam int HI_BITS = ADDR_W - VRAM_BITS;

  logic [PTR_REGS-1:0][DATA_W-1:0] ptrReg;
  logic [ADDR_W-1:0]    srcAligned, dstRaw, srcCnt, srcNext;
  logic [VRAM_BITS-1:0] dstOff, dstOffInit, dstOffNext;
  logic [ADDR_W-1:0]    dstFull, dstNextFull;
  logic [PTR_REGS-1:0][DATA_W-1:0] wbByte;

  assign srcAligned = {ptrReg[0], ptrReg[1]} & ALIGN_MASK;
  assign dstRaw     = {ptrReg[2], ptrReg[3]} & ALIGN_MASK;
  assign dstOffInit = dstRaw[VRAM_BITS-1:0];
  assign srcInvalid = (srcAligned[ADDR_W-1:VRAM_BITS] == VRAM_BASE[ADDR_W-1:VRAM_BITS]);

  // values after the current step, used when writing back on the last byte
  assign srcNext     = strb.step ? srcCnt + 1'b1 : srcCnt;
  assign dstOffNext  = strb.step ? dstOff + 1'b1 : dstOff;
  assign dstFull     = {VRAM_BASE[ADDR_W-1:VRAM_BITS], dstOff};
  assign dstNextFull = {VRAM_BASE[ADDR_W-1:VRAM_BITS], dstOffNext};

  assign wbByte[0] = srcNext[ADDR_W-1:DATA_W];
  assign wbByte[1] = srcNext[DATA_W-1:0];
  assign wbByte[2] = dstNextFull[ADDR_W-1:DATA_W];
  assign wbByte[3] = dstNextFull[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcCnt <= '0;
      dstOff <= '0;
    end else if (strb.load) begin
      srcCnt <= srcAligned;
      dstOff <= dstOffInit;
    end else begin
      srcCnt <= srcNext;
      dstOff <= dstOffNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0;
    end else begin
      for (int i = 0; i < PTR_REGS; i++) begin
        if (strb.writeBack)
          ptrReg[i] <= wbByte[i];
        else if (regWrEn && regAddr == 3'(i))
          ptrReg[i] <= regWrData;
      end
    end
  end

  assign dpRdData   = (regAddr < 3'(PTR_REGS)) ? ptrReg[regAddr[1:0]] : '1;
  assign memRdEn    = strb.byteWrite;
  assign memRdAddr  = srcCnt;
  assign vramWrEn   = strb.byteWrite;
  assign vramWrAddr = dstFull;
  assign vramWrData = memRdData;

  if (ALIGN_BITS + HI_BITS > ADDR_W) begin : g_bad_cfg
    initial $display("vram_copy_dp: block size and window overlap");
  end
endmodule

// File: rtl/vram_copy_ctrl.sv
module vram_copy_ctrl
  import vram_copy_pkg::*;
#(
  parameter int BLOCK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              hblank,
  input  logic [1:0]        videoMode,
  input  logic              srcInvalid,
  output dpStrobe_t         strb,
  output logic              cpuStall,
  output logic [DATA_W-1:0] lenRd
);
  localparam int ALIGN_BITS = $clog2(BLOCK_BYTES);
  localparam int CNT_W = LEN_BITS + ALIGN_BITS + 1;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t            state;
  logic              phase;
  logic [CNT_W-1:0]  remain;
  logic              hActive;
  logic              blockRun;
  logic [DATA_W-1:0] lenReg;
  logic              hbPrev;

  logic lenWrite, inHblankMode, startReq, wantPaced;
  logic doBulk, doCancel, doArm, doBlock, hbRise, lastByte;
  logic [LEN_BITS-1:0] reqBlocks;
  logic [CNT_W-1:0]    bulkBytes;

  assign lenWrite     = regWrEn && (regAddr == LEN_IDX);
  assign inHblankMode = (videoMode == 2'd0);
  assign startReq     = lenWrite && !srcInvalid && (state == ST_IDLE);
  assign wantPaced    = regWrData[DATA_W-1];
  assign reqBlocks    = regWrData[LEN_BITS-1:0];
  assign bulkBytes    = (CNT_W'(reqBlocks) + 1'b1) << ALIGN_BITS;

  assign doBulk   = startReq && !wantPaced && (!hActive || inHblankMode);
  assign doCancel = startReq && !wantPaced && hActive && !inHblankMode;
  assign doArm    = startReq && wantPaced;
  assign hbRise   = hblank && !hbPrev;
  assign doBlock  = (state == ST_IDLE) && !lenWrite && hActive && hbRise;
  assign lastByte = (state == ST_RUN) && phase && (remain == CNT_W'(1));

  always_comb begin
    strb           = '0;
    strb.load      = doBulk || doArm;
    strb.byteWrite = (state == ST_RUN) && phase;
    strb.step      = (state == ST_RUN) && phase;
    strb.writeBack = lastByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      remain   <= '0;
      hActive  <= 1'b0;
      blockRun <= 1'b0;
      lenReg   <= '1;
      hbPrev   <= 1'b0;
    end else begin
      hbPrev <= hblank;
      case (state)
        ST_IDLE: begin
          phase <= 1'b0;
          if (doBulk) begin
            state    <= ST_RUN;
            remain   <= bulkBytes;
            hActive  <= 1'b0;
            blockRun <= 1'b0;
          end else if (doCancel) begin
            hActive <= 1'b0;
            lenReg  <= {1'b1, lenReg[LEN_BITS-1:0]};
          end else if (doArm) begin
            hActive <= 1'b1;
            lenReg  <= {1'b0, reqBlocks};
            if (inHblankMode) begin
              state    <= ST_RUN;
              remain   <= CNT_W'(BLOCK_BYTES);
              blockRun <= 1'b1;
            end
          end else if (doBlock) begin
            state    <= ST_RUN;
            remain   <= CNT_W'(BLOCK_BYTES);
            blockRun <= 1'b1;
          end
        end
        ST_RUN: begin
          phase <= ~phase;
          if (phase) begin
            remain <= remain - 1'b1;
            if (remain == CNT_W'(1)) begin
              state <= ST_IDLE;
              if (!blockRun) begin
                lenReg <= '1;
              end else if (lenReg[LEN_BITS-1:0] == '0) begin
                lenReg  <= '1;
                hActive <= 1'b0;
              end else begin
                lenReg <= lenReg - 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpuStall = (state == ST_RUN);
  assign lenRd    = lenReg;
endmodule

// File: rtl/vram_copy_engine.sv
module vram_copy_engine
  import vram_copy_pkg::*;
#(
  parameter int BLOCK_BYTES = 16,
  parameter logic [15:0] VRAM_BASE = 16'h8000,
  parameter int VRAM_BITS = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        hblank,
  input  logic [1:0]  videoMode,
  output logic        cpuStall,
  output logic        memRdEn,
  output logic [15:0] memRdAddr,
  input  logic [7:0]  memRdData,
  output logic        vramWrEn,
  output logic [15:0] vramWrAddr,
  output logic [7:0]  vramWrData
);
  dpStrobe_t         strb;
  logic              srcInvalid;
  logic [DATA_W-1:0] dpRdData, lenRd;

  vram_copy_ctrl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .hblank(hblank), .videoMode(videoMode),
    .srcInvalid(srcInvalid), .strb(strb), .cpuStall(cpuStall), .lenRd(lenRd)
  );

  vram_copy_dp #(
    .BLOCK_BYTES(BLOCK_BYTES), .VRAM_BASE(VRAM_BASE), .VRAM_BITS(VRAM_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strb(strb), .memRdData(memRdData),
    .dpRdData(dpRdData), .srcInvalid(srcInvalid), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .vramWrEn(vramWrEn), .vramWrAddr(vramWrAddr),
    .vramWrData(vramWrData)
  );

  assign regRdData = (regAddr == LEN_IDX) ? lenRd : dpRdData;
endmodule

// File: rtl/vram_copy_chk.sv
module vram_copy_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        cpuStall,
  input logic        vramWrEn,
  input logic [15:0] vramWrAddr,
  input logic [15:0] memRdAddr
);
  // input assumption: a stalled CPU issues no register writes
  p_no_write_in_stall_r12: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> !regWrEn);

  p_write_in_stall_r12: assert property (@(posedge clk) disable iff (!rstN)
    vramWrEn |-> cpuStall);

  p_dst_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    vramWrEn |-> vramWrAddr[15:13] == 3'b100);

  p_byte_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
    vramWrEn |=> !vramWrEn);

  p_idle_half_then_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuStall && !vramWrEn) |=> vramWrEn);

  p_src_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (vramWrEn && $past(vramWrEn, 2) && $past(cpuStall, 1)) |->
      memRdAddr == $past(memRdAddr, 2) + 16'd1);

  p_aligned_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |-> (memRdAddr[3:0] == 4'h0 && vramWrAddr[3:0] == 4'h0));
endmodule

bind vram_copy_engine vram_copy_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .cpuStall(cpuStall),
  .vramWrEn(vramWrEn), .vramWrAddr(vramWrAddr), .memRdAddr(memRdAddr)
);

// File: tb/vram_copy_engine_tb.sv
`timescale 1ns/1ps
module vram_copy_engine_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [7:0]  regRdData;
  logic        hblank = 1'b0;
  logic [1:0]  videoMode = 2'd3;
  logic        cpuStall, memRdEn, vramWrEn;
  logic [15:0] memRdAddr, vramWrAddr;
  logic [7:0]  memRdData, vramWrData;

  int checks = 0;
  int failures = 0;
  int logCnt = 0;
  int stallCnt = 0;
  logic [15:0] logA [0:511];
  logic [7:0]  logD [0:511];

  always #4 clk = ~clk;

  assign memRdData = memRdAddr[7:0] ^ memRdAddr[15:8] ^ 8'h5A;

  vram_copy_engine u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hblank(hblank),
    .videoMode(videoMode), .cpuStall(cpuStall), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .vramWrEn(vramWrEn),
    .vramWrAddr(vramWrAddr), .vramWrData(vramWrData)
  );

  always @(posedge clk) begin
    if (vramWrEn && logCnt < 512) begin
      logA[logCnt] <= vramWrAddr;
      logD[logCnt] <= vramWrData;
      logCnt <= logCnt + 1;
    end
    if (cpuStall) stallCnt <= stallCnt + 1;
  end

  function automatic logic [7:0] srcByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    int guard = 0;
    @(negedge clk);
    while (cpuStall && guard < 10000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic setPtrs(input logic [15:0] s, input logic [15:0] d);
    wrReg(3'd0, s[15:8]); wrReg(3'd1, s[7:0]);
    wrReg(3'd2, d[15:8]); wrReg(3'd3, d[7:0]);
  endtask

  task automatic pulseHblank();
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
    waitIdle();
  endtask

  // compare writes from log index base against expected src/dst stream
  task automatic chkStream(input string tag, input int base, input int n,
                           input logic [15:0] s0, input logic [15:0] dOff0);
    int bad = -1;
    for (int k = 0; k < n; k++) begin
      logic [15:0] ea, es;
      es = s0 + 16'(k);
      ea = 16'h8000 | ((dOff0 + 16'(k)) & 16'h1FFF);
      if (bad < 0 && (logA[base+k] !== ea || logD[base+k] !== srcByte(es))) bad = k;
    end
    if (bad >= 0) begin
      logic [15:0] ea2;
      ea2 = 16'h8000 | ((dOff0 + 16'(bad)) & 16'h1FFF);
      chk(1'b0, tag, int'(logA[base+bad]), int'(ea2));
    end else chk(1'b1, tag, 0, 0);
  endtask

  task automatic chkReg(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] d;
    rdReg(a, d);
    chk(d === e, tag, int'(d), int'(e));
  endtask

  task automatic t_reset();
    chkReg("R1 idx0", 3'd0, 8'h00);
    chkReg("R1 idx3", 3'd3, 8'h00);
    chkReg("R1 idx4", 3'd4, 8'hFF);
    chkReg("R1 idx6", 3'd6, 8'hFF);
    chk(cpuStall == 1'b0 && logCnt == 0, "R1 stall/writes", int'(cpuStall), 0);
  endtask

  task automatic t_bulk();
    int b, s;
    setPtrs(16'h1234, 16'h0A57);
    b = logCnt; s = stallCnt;
    wrReg(3'd4, 8'h01);
    waitIdle();
    chk(logCnt - b == 32, "R5 byte count", logCnt - b, 32);
    chk(stallCnt - s == 64, "R5 stall cycles", stallCnt - s, 64);
    chkStream("R2 R3 R5 bulk stream", b, 32, 16'h1230, 16'h0A50);
    chkReg("R6 len after bulk", 3'd4, 8'hFF);
    chkReg("R6 src hi", 3'd0, 8'h12);
    chkReg("R6 src lo", 3'd1, 8'h50);
    chkReg("R6 dst hi", 3'd2, 8'h8A);
    chkReg("R6 dst lo", 3'd3, 8'h70);
  endtask

  task automatic t_wrap();
    int b;
    setPtrs(16'hC000, 16'hFFFF);
    b = logCnt;
    wrReg(3'd4, 8'h01);
    waitIdle();
    chk(logCnt - b == 32, "R3 wrap count", logCnt - b, 32);
    chkStream("R3 wrap stream", b, 32, 16'hC000, 16'h1FF0);
    chkReg("R3 dst hi after wrap", 3'd2, 8'h80);
    chkReg("R3 dst lo after wrap", 3'd3, 8'h10);
  endtask

  task automatic t_invalid();
    int b, s;
    setPtrs(16'h9008, 16'h0000);
    b = logCnt; s = stallCnt;
    wrReg(3'd4, 8'h03);
    repeat (20) @(negedge clk);
    chk(logCnt == b, "R4 no writes", logCnt - b, 0);
    chk(stallCnt == s, "R4 no stall", stallCnt - s, 0);
    chkReg("R4 len unchanged", 3'd4, 8'hFF);
  endtask

  task automatic t_paced();
    int b;
    videoMode = 2'd3;
    setPtrs(16'h4000, 16'h0100);
    b = logCnt;
    wrReg(3'd4, 8'h82);
    repeat (10) @(negedge clk);
    chk(logCnt == b, "R7 armed no move", logCnt - b, 0);
    chkReg("R7 len armed", 3'd4, 8'h02);
    pulseHblank();
    chk(logCnt - b == 16, "R7 first block", logCnt - b, 16);
    chkReg("R7 len after 1", 3'd4, 8'h01);
    chkReg("R11 src lo after 1", 3'd1, 8'h10);
    chkReg("R11 dst hi after 1", 3'd2, 8'h81);
    chkReg("R11 dst lo after 1", 3'd3, 8'h10);
    pulseHblank();
    chkReg("R7 len after 2", 3'd4, 8'h00);
    pulseHblank();
    chk(logCnt - b == 48, "R7 three blocks", logCnt - b, 48);
    chkStream("R11 paced stream", b, 48, 16'h4000, 16'h0100);
    chkReg("R7 len done", 3'd4, 8'hFF);
    pulseHblank();
    chk(logCnt - b == 48, "R7 edge after done", logCnt - b, 48);
  endtask

  task automatic t_paced_now();
    int b;
    videoMode = 2'd0;
    setPtrs(16'h2200, 16'h0400);
    b = logCnt;
    wrReg(3'd4, 8'h81);
    waitIdle();
    chk(logCnt - b == 16, "R8 immediate block", logCnt - b, 16);
    chkReg("R8 len after first", 3'd4, 8'h00);
    videoMode = 2'd3;
    pulseHblank();
    chk(logCnt - b == 32, "R8 second block", logCnt - b, 32);
    chkStream("R8 stream", b, 32, 16'h2200, 16'h0400);
    chkReg("R8 len done", 3'd4, 8'hFF);
  endtask

  task automatic t_cancel();
    int b;
    videoMode = 2'd3;
    setPtrs(16'h3000, 16'h0200);
    wrReg(3'd4, 8'h85);
    pulseHblank();
    chkReg("R9 len mid", 3'd4, 8'h04);
    b = logCnt;
    wrReg(3'd4, 8'h00);
    repeat (20) @(negedge clk);
    chk(logCnt == b, "R9 cancel moves nothing", logCnt - b, 0);
    chkReg("R9 len cancelled", 3'd4, 8'h84);
    pulseHblank();
    chk(logCnt == b, "R9 edge after cancel", logCnt - b, 0);
  endtask

  task automatic t_override();
    int b;
    videoMode = 2'd3;
    setPtrs(16'h5000, 16'h0300);
    b = logCnt;
    wrReg(3'd4, 8'h83);
    repeat (5) @(negedge clk);
    chk(logCnt == b, "R10 armed", logCnt - b, 0);
    setPtrs(16'h6000, 16'h0600);
    videoMode = 2'd0;
    wrReg(3'd4, 8'h01);
    waitIdle();
    chk(logCnt - b == 32, "R10 bulk length", logCnt - b, 32);
    chkStream("R10 bulk stream", b, 32, 16'h6000, 16'h0600);
    chkReg("R10 len done", 3'd4, 8'hFF);
    videoMode = 2'd3;
    pulseHblank();
    chk(logCnt - b == 32, "R10 paced dropped", logCnt - b, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bulk();
    t_wrap();
    t_invalid();
    t_paced();
    t_paced_now();
    t_cancel();
    t_override();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule